// File: doc/BRIEF.md
# Processor Idle Clock Gate Controller

This block decides when the processor clock may run. It drives a clock-enable level toward an external glitch-free gating cell. Software stops the processor by writing a stop request over a small register-bus slave. The enable does not drop straight away. It drops only when the processor reports that the instruction in progress has retired. Any interrupt request whose per-source mask is set brings the clock back with no software action, and so does reset. A software write to the start register also brings it back.

The bus slave and this controller run on the free-running system clock, not on the gated clock. Other bus masters therefore keep making transfers while the processor sleeps, and the slave keeps answering accesses. A status register shows the gate state. It lags the enable output by one cycle, so it reports what the gate has actually done, not what was asked for.

Top module: `cpu_idle_gate`

## Requirements
- R1: After reset, `cpu_clk_en` is 1 and the status bit (bit 0 at word offset 2) reads 1.
- R2: A write with bit 0 = 1 to the stop register (word offset 1) leaves `cpu_clk_en` at 1 until `insn_done` is sampled high at a later edge. `cpu_clk_en` is 0 from the edge where that happens.
- R3: The status bit equals the value `cpu_clk_en` had one cycle earlier. Every other status bit reads 0.
- R4: While stopped, a wake request (any `irq_req[i]` with `irq_en[i]` = 1, or `fast_req` with `fast_en` = 1) sampled at an edge sets `cpu_clk_en` to 1 from that edge.
- R5: An enabled wake request that arrives while a stop is pending cancels the stop. `cpu_clk_en` stays 1, and later `insn_done` pulses do not stop the clock.
- R6: A request whose mask bit is 0 has no effect on `cpu_clk_en`.
- R7: Writes with bit 0 = 0 to the start or stop register have no effect. Writes to the status register or to an unmapped offset have no effect.
- R8: A write with bit 0 = 1 to the start register (word offset 0) sets `cpu_clk_en` to 1 from that edge, whether the gate is stopped or a stop is pending.
- R9: The bus slave keeps working while the processor clock is stopped. Reads of the start, stop and unmapped offsets return 0.
- R10: An `insn_done` pulse in the same cycle as the stop write does not stop the clock. An enabled wake request in that same cycle cancels the stop write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Slave selected this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq_req | input | N_IRQ | Normal interrupt requests |
| irq_en | input | N_IRQ | Per-source normal interrupt mask, 1 = enabled |
| fast_req | input | 1 | Fast interrupt request |
| fast_en | input | 1 | Fast interrupt mask, 1 = enabled |
| insn_done | input | 1 | Processor instruction-retire pulse |
| cpu_clk_en | output | 1 | Enable to the processor clock gating cell |

## Verification
The case that is hardest to reach is a stop that is still pending at the moment an enabled request arrives. It needs a stop write, then no retire pulse, then an unmasked request, all in a short window. The directed part builds this case directly, including the variant where all three fall in a single cycle. The random part keeps the retire probability low and issues stop writes often, so pending windows are long and many requests land inside them.

// File: rtl/cig_pkg.sv
// Package: shared encodings for the processor idle clock gate.
// Assumes word-addressed registers with the control bit at bit 0.
package cig_pkg;
    localparam int unsigned OFF_START  = 0;
    localparam int unsigned OFF_STOP   = 1;
    localparam int unsigned OFF_STATUS = 2;
    localparam int unsigned CPU_BIT    = 0;

    typedef enum logic [1:0] {
        GATE_RUN  = 2'd0,
        GATE_PEND = 2'd1,
        GATE_IDLE = 2'd2
    } gate_state_e;
endpackage

// File: rtl/cig_wake.sv
// Module: cig_wake
// Combines the interrupt requests with their masks into one wake level.
// Assumes requests are level signals that are already synchronous to clk.
module cig_wake #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             fast_req,
    input  logic             fast_en,
    output logic             wake
);
    logic [N_IRQ-1:0] qual;

    // Qualify each normal source with its own mask bit.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign qual[i] = irq_req[i] & irq_en[i];
    end

    // Any qualified source, normal or fast, raises the wake level.
    always_comb begin
        wake = (fast_req & fast_en) | (|qual);
    end
endmodule

// File: rtl/cig_regif.sv
// Module: cig_regif
// Register-bus slave. It turns writes into start/stop pulses and holds the
// status flop, which lags the gate enable by one cycle.
// Assumes single-cycle accesses and combinational read data.
module cig_regif
    import cig_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              clk_en_in,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFF_START);
    localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(OFF_STOP);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

    logic wr_acc;
    logic status_q;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;

    // Decode writes that carry a 1 in the processor bit.
    always_comb begin
        wr_acc      = bus_sel & bus_we & bus_wdata[CPU_BIT];
        start_pulse = wr_acc & (bus_addr == A_START);
        stop_pulse  = wr_acc & (bus_addr == A_STOP);
    end

    // Status copy of the gate enable, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b1;
        else        status_q <= clk_en_in;
    end

    // Read mux: only the status offset returns data.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && bus_addr == A_STATUS)
            bus_rdata[CPU_BIT] = status_q;
    end

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_in != status_q) |=> (status_q == $past(clk_en_in))); // R3
    AST_STOP_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R7
endmodule

// File: rtl/cig_fsm.sv
// Module: cig_fsm
// Gate state machine: run, stop pending, idle. A wake request or a start
// write wins over everything else. A pending stop completes on a retire pulse.
// Assumes insn_done is one-cycle per retired instruction.
module cig_fsm
    import cig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_pulse,
    input  logic stop_pulse,
    input  logic wake,
    input  logic insn_done,
    output logic clk_en
);
    gate_state_e state_q, state_d;

    // Next-state selection with wake/start priority.
    always_comb begin
        state_d = state_q;
        if (wake || start_pulse) begin
            state_d = GATE_RUN;
        end else begin
            unique case (state_q)
                GATE_RUN:  if (stop_pulse) state_d = GATE_PEND;
                GATE_PEND: if (insn_done)  state_d = GATE_IDLE;
                GATE_IDLE: state_d = GATE_IDLE;
                default:   state_d = GATE_RUN;
            endcase
        end
    end

    // State register, running after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_RUN;
        else        state_q <= state_d;
    end

    assign clk_en = (state_q != GATE_IDLE);

    AST_WAKE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> clk_en); // R4
    AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !insn_done) |=> clk_en); // R2
    AST_PEND_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == GATE_PEND) |-> $past(stop_pulse)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !wake && !start_pulse) |=> !clk_en); // R6
endmodule

// File: rtl/cpu_idle_gate.sv
// Module: cpu_idle_gate
// Top of the processor idle clock gate controller. It produces the enable
// for an external glitch-free gating cell. Everything here runs on the
// free-running system clock.
module cpu_idle_gate #(
    parameter int N_IRQ  = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              fast_req,
    input  logic              fast_en,
    input  logic              insn_done,
    output logic              cpu_clk_en
);
    logic wake;
    logic start_pulse;
    logic stop_pulse;

    cig_wake #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .fast_req(fast_req),
        .fast_en (fast_en),
        .wake    (wake)
    );

    cig_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .clk_en_in  (cpu_clk_en),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .bus_rdata  (bus_rdata)
    );

    cig_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .wake       (wake),
        .insn_done  (insn_done),
        .clk_en     (cpu_clk_en)
    );
endmodule

// File: tb/test_cpu_idle_gate.sv
module test_cpu_idle_gate;
    localparam int PERIOD = 10;
    localparam int N_IRQ  = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_sel, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_IRQ-1:0]  irq_req, irq_en;
    logic              fast_req, fast_en, insn_done;
    logic              cpu_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    int m_st;      // 0 run, 1 pending, 2 idle
    bit m_stat;

    always #(PERIOD/2) clk = ~clk;

    cpu_idle_gate #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cpu_idle_gate (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_en(irq_en), .fast_req(fast_req), .fast_en(fast_en),
        .insn_done(insn_done), .cpu_clk_en(cpu_clk_en)
    );

    function automatic int next_st(int st, bit st_w, bit sp_w, bit wk, bit done);
        if (wk || st_w) return 0;
        if (st == 0) return sp_w ? 1 : 0;
        if (st == 1) return done ? 2 : 1;
        return 2;
    endfunction

    function automatic bit exp_wake();
        return fast_req & fast_en | (|(irq_req & irq_en));
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        irq_req = '0; fast_req = 0; insn_done = 0;
    endtask

    // One clock: update the model at the edge, then check the enable.
    task automatic tick(string tag);
        bit st_w, sp_w;
        @(posedge clk);
        st_w = bus_sel && bus_we && bus_addr == 0 && bus_wdata[0];
        sp_w = bus_sel && bus_we && bus_addr == 1 && bus_wdata[0];
        m_stat = (m_st != 2);
        m_st = next_st(m_st, st_w, sp_w, exp_wake(), insn_done);
        @(negedge clk);
        check(tag, {31'b0, cpu_clk_en}, {31'b0, m_st != 2});
        idle_inputs();
    endtask

    task automatic read_chk(string tag, int a, logic [DATA_W-1:0] exp);
        bus_sel = 1; bus_we = 0; bus_addr = ADDR_W'(a);
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic wr(int a, logic [DATA_W-1:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        irq_en = '0; fast_en = 0;
        rst_n = 0;
        m_st = 0; m_stat = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 enable", {31'b0, cpu_clk_en}, 32'd1);
        read_chk("R1 status", 2, 32'd1);
        tick("R1");

        // R10: retire in the same cycle as the stop write does not stop
        wr(1, 32'h1); insn_done = 1; tick("R10");
        tick("R2 pending holds");
        tick("R2 pending holds");
        insn_done = 1; tick("R2 stop at boundary");
        read_chk("R3 status lags", 2, 32'd1);
        tick("R3");
        read_chk("R3 status now off", 2, 32'd0);
        // R9 reads while idle
        read_chk("R9 start reads 0", 0, 32'd0);
        read_chk("R9 stop reads 0", 1, 32'd0);
        read_chk("R9 unmapped reads 0", 5, 32'd0);
        tick("R9");
        // R7 writes with bit 0 clear, status write, unmapped write
        wr(0, 32'hFFFF_FFFE); tick("R7 start zero bit");
        wr(2, 32'hFFFF_FFFF); tick("R7 status write");
        wr(7, 32'hFFFF_FFFF); tick("R7 unmapped write");
        // R6 masked requests
        irq_en = 8'h0F; irq_req = 8'hF0; fast_req = 1; fast_en = 0; tick("R6 masked");
        // R4 enabled fast request wakes
        fast_req = 1; fast_en = 1; tick("R4 fast wake");
        fast_en = 0;
        // R5 wake during pending cancels
        wr(1, 32'h1); tick("R5 stop write");
        irq_req = 8'h01; tick("R5 cancel");
        insn_done = 1; tick("R5 no stop after cancel");
        // R10 wake in same cycle as stop write
        wr(1, 32'h1); irq_req = 8'h02; tick("R10 wake wins");
        insn_done = 1; tick("R10 no stop");
        // R8 software start from pending and from idle
        wr(1, 32'h1); tick("R8 stop");
        wr(0, 32'h1); tick("R8 start from pending");
        insn_done = 1; tick("R8 stays");
        wr(1, 32'h1); tick("R8 stop");
        insn_done = 1; tick("R8 idle");
        wr(1, 32'h0); tick("R7 stop zero bit");
        wr(0, 32'h1); tick("R8 start from idle (R9)");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            irq_en  = N_IRQ'($urandom);
            fast_en = ($urandom % 2) == 1;
            irq_req = (($urandom % 16) == 0) ? N_IRQ'(1 << ($urandom % N_IRQ)) : '0;
            fast_req = ($urandom % 24) == 0;
            insn_done = ($urandom % 8) == 0;
            r = $urandom % 10;
            if (r < 3) wr(1, DATA_W'($urandom) | 32'h1);
            else if (r < 4) wr(0, ($urandom % 3 == 0) ? 32'h1 : 32'h0);
            else if (r < 5) wr($urandom % 16, DATA_W'($urandom));
            else if (r < 8) read_chk("R3 random status", 2, {31'b0, m_stat});
            tick("R2 R4 R5 R6 random");
        end
        summary();
    end
endmodule